// File: doc/BRIEF.md
# Run-Level Coefficient Word Packer

This block sits between a coefficient decoder and a memory writer. It takes the decoded events of one 8x8 block of DCT coefficients and turns each one into a single 32-bit word. An event is either a run/level pair or, for an intra block, the DC term. The output is a stream of words with sideband flags. The first word of each block is marked as a start, and that marker also says whether the block is intra. After the last coefficient of each block the packer appends a terminator word by itself, so the memory writer never has to find block boundaries on its own.

Both sides use a valid/ready handshake. The packer has one output register. While the output is stalled it holds its word and takes no new input, so no word is lost or reordered. When the output is free it moves one word per clock. The only slot it adds is the terminator after each block, and the input waits for that one cycle.

For an intra block, the first event is the DC term. It is given as a bit count and a right-aligned value. The packer moves the value to the top of a 16-bit field and pairs it with the count. A count that cannot fit in 16 bits is clamped and recorded in a sticky error flag.

Top module: `rl_word_packer`

## Requirements
- R1: After reset, out_valid is 0, dc_err is 0 and in_ready is 1.
- R2: An accepted event that is not a DC term produces the word {run zero-extended to 16 bits in [31:16], level as two's complement sign-extended to 16 bits in [15:0]}.
- R3: An accepted event with in_sop=1 and in_intra=1 is a DC term. It produces {size in [31:16], value in [15:0]}. The value field holds the low `size` bits of in_dc_val in its top `size` bits, and every bit below them is zero. A size of 0 gives a value field of 0.
- R4: A DC size greater than 16 is packed as size 16 with the full 16-bit value, and it sets dc_err. Only reset clears dc_err.
- R5: The first word of a block has out_sop=1. Its out_intra is 1 for an intra DC word and 0 for a non-intra block, which starts directly with a run/level word. All other words have out_sop=0 and out_intra=0.
- R6: After an event with in_last=1 is accepted, in_ready is 0 in the next cycle. The word that follows that block's last word is the terminator 0x00FF0000 with out_eob=1. It appears in the cycle after the last word is accepted.
- R7: While out_valid=1 and out_ready=0, out_valid, out_word and the output flags hold their values. All words leave in input order, with none lost and none duplicated.
- R8: Whenever out_valid is 0, or out_ready is 1 and no terminator is pending, in_ready is 1. This gives one word per clock under a free-flowing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input event valid |
| in_ready | output | 1 | Packer can accept an event |
| in_sop | input | 1 | First event of a block |
| in_intra | input | 1 | With in_sop: block is intra and this event is its DC term |
| in_last | input | 1 | Last event of a block |
| in_run | input | RUN_W | Zero-run length before the coefficient |
| in_level | input | LVL_W | Signed coefficient level |
| in_dc_size | input | SZ_W | DC term bit count |
| in_dc_val | input | 16 | DC term, right-aligned |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Memory writer accepts the word |
| out_word | output | 32 | Packed word |
| out_sop | output | 1 | First word of a block |
| out_intra | output | 1 | First word is an intra DC word |
| out_eob | output | 1 | Word is the block terminator |
| dc_err | output | 1 | Sticky: a DC size above 16 was seen |

## Verification
A wrong pending-terminator state shows up at the ports within one or two cycles. It can appear as in_ready staying high right after a last event, or as a missing or doubled 0x00FF0000 word in the stream. The queue model detects either one at the next output handshake. A wrong output register shows up when a word changes under back-pressure, or when the word that leaves differs from the head of the expected queue. The DC shift and clamp path is checked for every DC word, at sizes 0, 1, 8, 16 and above 16. dc_err is compared against the model on every cycle, so a flag that fails to stick, or that sets on the wrong event, is caught in the cycle after it happens.

// File: rtl/rl_word_packer.sv
module rl_word_packer #(
  parameter int RUN_W = 6,
  parameter int LVL_W = 12,
  parameter int SZ_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sop,
  input  logic                    in_intra,
  input  logic                    in_last,
  input  logic [RUN_W-1:0]        in_run,
  input  logic signed [LVL_W-1:0] in_level,
  input  logic [SZ_W-1:0]         in_dc_size,
  input  logic [15:0]             in_dc_val,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [31:0]             out_word,
  output logic                    out_sop,
  output logic                    out_intra,
  output logic                    out_eob,
  output logic                    dc_err
);
  localparam int          HALF      = 16;
  localparam logic [31:0] TERM_WORD = 32'h00FF_0000;

  logic        vld_q, sop_q, intra_q, eob_q, err_q, term_pend;
  logic [31:0] word_q;

  logic            take, is_dc, over;
  logic [SZ_W-1:0] sz;
  logic [SZ_W:0]   shamt;
  logic [15:0]     dc_field;
  logic [31:0]     dc_word, ac_word;

  assign in_ready = !term_pend && (!vld_q || out_ready);
  assign take     = in_valid && in_ready;
  assign is_dc    = in_sop && in_intra;
  assign over     = in_dc_size > SZ_W'(HALF);
  assign sz       = over ? SZ_W'(HALF) : in_dc_size;
  assign shamt    = (SZ_W+1)'(HALF) - {1'b0, sz};
  assign dc_field = in_dc_val << shamt;
  assign dc_word  = {16'(sz), dc_field};
  assign ac_word  = {16'(in_run), {(HALF-LVL_W){in_level[LVL_W-1]}}, in_level};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      sop_q     <= 1'b0;
      intra_q   <= 1'b0;
      eob_q     <= 1'b0;
      err_q     <= 1'b0;
      term_pend <= 1'b0;
      word_q    <= '0;
    end else if (take) begin
      vld_q     <= 1'b1;
      word_q    <= is_dc ? dc_word : ac_word;
      sop_q     <= in_sop;
      intra_q   <= is_dc;
      eob_q     <= 1'b0;
      term_pend <= in_last;
      if (is_dc && over) err_q <= 1'b1;
    end else if (vld_q && out_ready) begin
      if (term_pend) begin
        word_q    <= TERM_WORD;
        eob_q     <= 1'b1;
        sop_q     <= 1'b0;
        intra_q   <= 1'b0;
        term_pend <= 1'b0;
      end else begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign out_sop   = sop_q;
  assign out_intra = intra_q;
  assign out_eob   = eob_q;
  assign dc_err    = err_q;
endmodule

// File: rtl/rl_word_packer_chk.sv
module rl_word_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_sop,
  input logic        out_intra,
  input logic        out_eob,
  input logic        dc_err
);
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_eob)
                                && $stable(out_sop) && $stable(out_intra));

  p_stall_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);

  p_term_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eob |-> out_word == 32'h00FF_0000 && !out_sop);

  p_dc_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_intra |-> out_sop && out_word[31:16] <= 16'd16);

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dc_err |=> dc_err);

  p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind rl_word_packer rl_word_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_sop(out_sop), .out_intra(out_intra),
  .out_eob(out_eob), .dc_err(dc_err)
);

// File: tb/rl_word_packer_tb.sv
module rl_word_packer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, in_sop = 1'b0, in_intra = 1'b0, in_last = 1'b0;
  logic [5:0]  in_run = '0;
  logic signed [11:0] in_level = '0;
  logic [4:0]  in_dc_size = '0;
  logic [15:0] in_dc_val = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_sop, out_intra, out_eob, dc_err;
  logic [31:0] out_word;

  rl_word_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_intra(in_intra), .in_last(in_last), .in_run(in_run),
    .in_level(in_level), .in_dc_size(in_dc_size), .in_dc_val(in_dc_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_sop(out_sop), .out_intra(out_intra), .out_eob(out_eob), .dc_err(dc_err)
  );

  typedef struct packed {
    logic sop, intra, last;
    logic [5:0] run;
    logic [11:0] lvl;
    logic [4:0] sz;
    logic [15:0] dv;
  } ev_t;

  ev_t         evq[$];
  logic [34:0] expq[$];
  int vectors = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dc_word(input logic [4:0] sz, input logic [15:0] dv);
    int c;
    logic [15:0] v;
    c = (sz > 16) ? 16 : int'(sz);
    v = (c == 0) ? 16'h0 : 16'(dv << (16 - c));
    return {16'(c), v};
  endfunction

  function automatic logic [31:0] ac_word(input logic [5:0] r, input logic [11:0] l);
    return {16'(r), {4{l[11]}}, l};
  endfunction

  task automatic ev(input bit s, input bit i, input bit l, input int r, input int lv,
                    input int sz, input int dv);
    ev_t e;
    e.sop = s; e.intra = i; e.last = l; e.run = 6'(r); e.lvl = 12'(lv);
    e.sz = 5'(sz); e.dv = 16'(dv);
    evq.push_back(e);
  endtask

  task automatic rand_block(input int n);
    bit intra;
    intra = $urandom_range(0, 1) == 1;
    if (intra) ev(1, 1, n == 0, 0, 0, $urandom_range(0, 20), $urandom);
    for (int k = 0; k < n; k++)
      ev(!intra && k == 0, 0, k == n - 1, $urandom_range(0, 63), $urandom, 0, 0);
    if (!intra && n == 0) ev(1, 0, 1, 0, 1, 0, 0);
  endtask

  initial begin
    bit m_pend = 0, m_err = 0, last_acc = 0, term_next = 0, stall_prev = 0;
    bit acc_in, acc_out, watchdog = 0;
    logic [34:0] held = '0, e = '0, act;
    int cyc = 0;

    // R3 R2 R5: intra, size 8
    ev(1, 1, 0, 0, 0, 8, 'hA5);
    ev(0, 0, 0, 0, 5, 0, 0);
    ev(0, 0, 0, 3, -1, 0, 0);
    ev(0, 0, 1, 63, -2048, 0, 0);
    // R5: non-intra starts with run/level
    ev(1, 0, 0, 0, 1, 0, 0);
    ev(0, 0, 1, 10, 2047, 0, 0);
    // R3: size 0 DC-only block
    ev(1, 1, 1, 0, 0, 0, 'hFFFF);
    // R3: size 16 and size 1
    ev(1, 1, 0, 0, 0, 16, 'h8001);
    ev(0, 0, 1, 1, -7, 0, 0);
    ev(1, 1, 1, 0, 0, 1, 'h0001);
    ev(1, 0, 1, 2, 3, 0, 0);
    // R4: oversize
    ev(1, 1, 1, 0, 0, 20, 'h1234);
    for (int b = 0; b < 150; b++) rand_block($urandom_range(0, 8));

    repeat (3) @(negedge clk);
    chk(out_valid == 0 && dc_err == 0 && in_ready == 1, "R1 reset",
        {out_valid, dc_err, in_ready}, 35'h1);
    rst_n = 1'b1;

    while (evq.size() != 0 || expq.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin watchdog = 1; break; end
      if (stall_prev)
        chk(out_valid && {out_sop, out_intra, out_eob, out_word} == held, "R7 hold",
            {out_sop, out_intra, out_eob, out_word}, held);
      if (term_next)
        chk(out_valid && out_eob, "R6 terminator next cycle", {33'h0, out_valid, out_eob}, 35'h3);
      chk(dc_err == m_err, "R4 dc_err", 35'(dc_err), 35'(m_err));
      if (cyc < 400) out_ready = 1'b1;
      else if (cyc < 1500) out_ready = $urandom_range(0, 1) == 1;
      else out_ready = $urandom_range(0, 4) == 0;
      if (evq.size() != 0 && $urandom_range(0, 3) != 0) begin
        in_valid = 1'b1; in_sop = evq[0].sop; in_intra = evq[0].intra; in_last = evq[0].last;
        in_run = evq[0].run; in_level = evq[0].lvl; in_dc_size = evq[0].sz; in_dc_val = evq[0].dv;
      end else in_valid = 1'b0;
      #1;
      if (last_acc) chk(!in_ready, "R6 input stall", 35'(in_ready), 35'h0);
      if ((!m_pend && out_ready) || !out_valid)
        chk(in_ready, "R8 ready", 35'(in_ready), 35'h1);
      acc_out = out_valid && out_ready;
      acc_in  = in_valid && in_ready;
      term_next = 0;
      if (acc_out) begin
        act = {out_sop, out_intra, out_eob, out_word};
        if (expq.size() == 0) chk(0, "R7 extra word", act, 35'h0);
        else begin
          e = expq.pop_front();
          chk(act == e, e[32] ? "R6 terminator" : (e[33] ? "R3 dc word" : "R2 R5 word"), act, e);
        end
        if (m_pend) begin term_next = 1; m_pend = 0; end
      end
      last_acc = 0;
      if (acc_in) begin
        if (evq[0].sop && evq[0].intra) begin
          expq.push_back({3'b110, dc_word(evq[0].sz, evq[0].dv)});
          if (evq[0].sz > 16) m_err = 1;
        end else
          expq.push_back({evq[0].sop, 2'b00, ac_word(evq[0].run, evq[0].lvl)});
        if (evq[0].last) begin
          expq.push_back({3'b001, 32'h00FF_0000});
          m_pend = 1; last_acc = 1;
        end
        void'(evq.pop_front());
      end
      stall_prev = out_valid && !out_ready;
      held = {out_sop, out_intra, out_eob, out_word};
    end
    in_valid = 1'b0;
    if (watchdog) chk(0, "watchdog", 35'(cyc), 35'h0);
    chk(expq.size() == 0, "R7 all words delivered", 35'(expq.size()), 35'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule